// File: doc/BRIEF.md
# SPI Controller Interrupt Status and Mask Unit

This unit is the interrupt front end of a FIFO-based SPI controller. Each clock it evaluates six event conditions from FIFO occupancy counts and error pulses that the FIFOs supply, and latches them into a status register. Software clears status bits by writing ones to them. An enable mask selects which latched events reach the single level interrupt line.

The mask has no direct write path. A write-only "set" register turns mask bits on and a write-only "clear" register turns them off, and a read-only register shows the current mask. The unit also holds the TX and RX watermark registers. Their values set the thresholds for the TX-below-watermark event and the RX-data-available event. With a TX watermark of 1, the TX event means the TX FIFO is empty.

The register port is a plain address, write strobe and write data bus. Read data is a combinational decode of the current address.

Top module: `spi_irq_regs`

## Requirements
- R1: Status bit 3 is set while `tx_count` equals FIFO_DEPTH, and status bit 5 is set while `rx_count` equals FIFO_DEPTH. Each is latched on the clock edge after the condition is seen.
- R2: Status bit 2 is set on every clock where `tx_count` is strictly less than the TX watermark.
- R3: Status bit 4 is set on every clock where `rx_count` is greater than or equal to the RX watermark.
- R4: A `rx_overflow` pulse sets status bit 0, and a `tx_underflow` pulse sets status bit 6. Both bits stay set until software clears them.
- R5: Writing to offset 0x04 clears each status bit whose write-data bit is 1. Bits written as 0 are unchanged. A level condition that is still true sets its bit again on the same edge.
- R6: Writing to offset 0x08 sets each mask bit whose write-data bit is 1. Writing to offset 0x0C clears each mask bit whose write-data bit is 1. Bits written as 0 are unchanged.
- R7: Offset 0x10 reads the mask and ignores writes. Offsets 0x08 and 0x0C read as 0. Offset 0x04 reads the status in bits 6:0.
- R8: The TX watermark is read and written at offset 0x28, and the RX watermark at offset 0x2C. Each uses bits CNT_W-1:0. Their reset values are 1 and 32.
- R9: `irq` equals the OR of (status AND mask) as it stood one clock earlier. Bit 1 and all bits above 6 never read as 1 in the status or mask registers.
- R10: While `rst_n` is low, status and mask read as 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` |
| tx_count | input | CNT_W | TX FIFO occupancy |
| rx_count | input | CNT_W | RX FIFO occupancy |
| rx_overflow | input | 1 | One-cycle pulse: push into a full RX FIFO |
| tx_underflow | input | 1 | One-cycle pulse: pop from an empty TX FIFO |
| irq | output | 1 | Level interrupt |

## Verification
The bench targets the following corner cases:

- **Clear versus live level condition.** The bench writes a clear to status bit 2 while the TX FIFO is still below its watermark. A design that lets the clear win would show the bit at 0 for a cycle, and `irq` would glitch low.
- **Watermark boundaries.** The bench drives counts exactly at, one below, and one above each watermark. An off-by-one comparison would show up as a status bit that is wrongly set or wrongly clear.
- **Sticky error bits.** The bench holds the overflow and underflow bits across many idle cycles, then clears only one of them. This catches a design that loses a sticky bit or clears its neighbour.
- **Mask registers.** The bench writes to the read-only mask offset and writes zeros to the set and clear registers. A design that treats these writes as plain stores would change the mask.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

    localparam int IRQ_W = 7;

    localparam int B_RX_OVF   = 0;
    localparam int B_TX_LOW   = 2;
    localparam int B_TX_FULL  = 3;
    localparam int B_RX_AVAIL = 4;
    localparam int B_RX_FULL  = 5;
    localparam int B_TX_UNDER = 6;

    localparam logic [IRQ_W-1:0] IRQ_VALID = 7'b111_1101;

    localparam int OFS_STATUS = 'h04;
    localparam int OFS_MSET   = 'h08;
    localparam int OFS_MCLR   = 'h0C;
    localparam int OFS_MASK   = 'h10;
    localparam int OFS_TXWM   = 'h28;
    localparam int OFS_RXWM   = 'h2C;

    typedef struct packed {
        logic [IRQ_W-1:0] status;
        logic [IRQ_W-1:0] mask;
        logic             irq;
    } irq_state_t;

endpackage

// File: rtl/spi_irq_cond.sv
module spi_irq_cond
    import spi_irq_pkg::*;
#(
    parameter int FIFO_DEPTH = 63,
    parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic [CNT_W-1:0] tx_count,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] tx_wm,
    input  logic [CNT_W-1:0] rx_wm,
    input  logic             rx_overflow,
    input  logic             tx_underflow,
    output logic [IRQ_W-1:0] events
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FIFO_DEPTH);

    always_comb begin
        events             = '0;
        events[B_RX_OVF]   = rx_overflow;
        events[B_TX_LOW]   = (tx_count < tx_wm);
        events[B_TX_FULL]  = (tx_count == FULL_CNT);
        events[B_RX_AVAIL] = (rx_count >= rx_wm);
        events[B_RX_FULL]  = (rx_count == FULL_CNT);
        events[B_TX_UNDER] = tx_underflow;
    end

endmodule

// File: rtl/spi_irq_wm.sv
module spi_irq_wm #(
    parameter int CNT_W  = 6,
    parameter int TX_RST = 1,
    parameter int RX_RST = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_we,
    input  logic             rx_we,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] tx_wm,
    output logic [CNT_W-1:0] rx_wm
);

    typedef struct packed {
        logic [CNT_W-1:0] tx;
        logic [CNT_W-1:0] rx;
    } wm_t;

    wm_t wm_d, wm_q;

    always_comb begin
        wm_d = wm_q;
        if (tx_we) begin
            wm_d.tx = wdata;
        end
        if (rx_we) begin
            wm_d.rx = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wm_q.tx <= CNT_W'(TX_RST);
            wm_q.rx <= CNT_W'(RX_RST);
        end else begin
            wm_q <= wm_d;
        end
    end

    assign tx_wm = wm_q.tx;
    assign rx_wm = wm_q.rx;

endmodule

// File: rtl/spi_irq_stat.sv
module spi_irq_stat
    import spi_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IRQ_W-1:0] events,
    input  logic [IRQ_W-1:0] stat_clr,
    input  logic [IRQ_W-1:0] mask_set,
    input  logic [IRQ_W-1:0] mask_clr,
    output logic [IRQ_W-1:0] status,
    output logic [IRQ_W-1:0] mask,
    output logic             irq
);

    irq_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        // events win over a clear on the same edge
        st_d.status = ((st_q.status & ~stat_clr) | events) & IRQ_VALID;
        st_d.mask   = ((st_q.mask | mask_set) & ~mask_clr) & IRQ_VALID;
        st_d.irq    = |(st_q.status & st_q.mask);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status = st_q.status;
    assign mask   = st_q.mask;
    assign irq    = st_q.irq;

endmodule

// File: rtl/spi_irq_regs.sv
module spi_irq_regs
    import spi_irq_pkg::*;
#(
    parameter int FIFO_DEPTH = 63,
    parameter int CNT_W      = $clog2(FIFO_DEPTH + 1),
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 32,
    parameter int TX_WM_RST  = 1,
    parameter int RX_WM_RST  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [CNT_W-1:0]  tx_count,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic              rx_overflow,
    input  logic              tx_underflow,
    output logic              irq
);

    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_MSET   = ADDR_W'(OFS_MSET);
    localparam logic [ADDR_W-1:0] A_MCLR   = ADDR_W'(OFS_MCLR);
    localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(OFS_MASK);
    localparam logic [ADDR_W-1:0] A_TXWM   = ADDR_W'(OFS_TXWM);
    localparam logic [ADDR_W-1:0] A_RXWM   = ADDR_W'(OFS_RXWM);

    logic [IRQ_W-1:0] events;
    logic [IRQ_W-1:0] stat_clr;
    logic [IRQ_W-1:0] mask_set;
    logic [IRQ_W-1:0] mask_clr;
    logic [IRQ_W-1:0] status_q;
    logic [IRQ_W-1:0] mask_q;
    logic [CNT_W-1:0] tx_wm_q;
    logic [CNT_W-1:0] rx_wm_q;
    logic             tx_wm_we;
    logic             rx_wm_we;
    logic [IRQ_W-1:0] wbits;

    assign wbits = reg_wdata[IRQ_W-1:0];

    // write decode
    always_comb begin
        stat_clr = '0;
        mask_set = '0;
        mask_clr = '0;
        tx_wm_we = 1'b0;
        rx_wm_we = 1'b0;
        if (reg_wr) begin
            case (reg_addr)
                A_STATUS: stat_clr = wbits;
                A_MSET:   mask_set = wbits;
                A_MCLR:   mask_clr = wbits;
                A_TXWM:   tx_wm_we = 1'b1;
                A_RXWM:   rx_wm_we = 1'b1;
                default:  ;
            endcase
        end
    end

    spi_irq_cond #(
        .FIFO_DEPTH (FIFO_DEPTH),
        .CNT_W      (CNT_W)
    ) u_cond (
        .tx_count     (tx_count),
        .rx_count     (rx_count),
        .tx_wm        (tx_wm_q),
        .rx_wm        (rx_wm_q),
        .rx_overflow  (rx_overflow),
        .tx_underflow (tx_underflow),
        .events       (events)
    );

    spi_irq_wm #(
        .CNT_W  (CNT_W),
        .TX_RST (TX_WM_RST),
        .RX_RST (RX_WM_RST)
    ) u_wm (
        .clk   (clk),
        .rst_n (rst_n),
        .tx_we (tx_wm_we),
        .rx_we (rx_wm_we),
        .wdata (reg_wdata[CNT_W-1:0]),
        .tx_wm (tx_wm_q),
        .rx_wm (rx_wm_q)
    );

    spi_irq_stat u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .events   (events),
        .stat_clr (stat_clr),
        .mask_set (mask_set),
        .mask_clr (mask_clr),
        .status   (status_q),
        .mask     (mask_q),
        .irq      (irq)
    );

    // read decode
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_STATUS: reg_rdata = {{(DATA_W-IRQ_W){1'b0}}, status_q};
            A_MASK:   reg_rdata = {{(DATA_W-IRQ_W){1'b0}}, mask_q};
            A_TXWM:   reg_rdata = {{(DATA_W-CNT_W){1'b0}}, tx_wm_q};
            A_RXWM:   reg_rdata = {{(DATA_W-CNT_W){1'b0}}, rx_wm_q};
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/spi_irq_chk.sv
module spi_irq_chk
    import spi_irq_pkg::*;
#(
    parameter int FIFO_DEPTH = 63,
    parameter int CNT_W      = 6,
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [CNT_W-1:0]  tx_count,
    input logic [CNT_W-1:0]  rx_count,
    input logic              rx_overflow,
    input logic              tx_underflow,
    input logic [IRQ_W-1:0]  status,
    input logic [IRQ_W-1:0]  mask,
    input logic              irq
);

    logic [IRQ_W-1:0] wv;
    logic             wr_stat;
    logic             wr_mset;
    logic             wr_mclr;

    assign wv      = reg_wdata[IRQ_W-1:0] & IRQ_VALID;
    assign wr_stat = reg_wr && (reg_addr == ADDR_W'(OFS_STATUS));
    assign wr_mset = reg_wr && (reg_addr == ADDR_W'(OFS_MSET));
    assign wr_mclr = reg_wr && (reg_addr == ADDR_W'(OFS_MCLR));

    a_r1_tx_full: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count == CNT_W'(FIFO_DEPTH)) |=> status[B_TX_FULL]);

    a_r4_ovf_sets: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overflow |=> status[B_RX_OVF]);

    a_r4_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (status[B_RX_OVF] && !(wr_stat && reg_wdata[B_RX_OVF])) |=> status[B_RX_OVF]);

    a_r4_udf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (status[B_TX_UNDER] && !(wr_stat && reg_wdata[B_TX_UNDER])) |=> status[B_TX_UNDER]);

    a_r6_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mset |=> ((mask & $past(wv)) == $past(wv)));

    a_r6_mask_clr: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mclr |=> ((mask & $past(wv)) == '0));

    a_r7_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_mset || wr_mclr) |=> $stable(mask));

    a_r9_irq_on: assert property (@(posedge clk) disable iff (!rst_n)
        (|(status & mask)) |=> irq);

    a_r9_irq_off: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(status & mask)) |=> !irq);

    a_r9_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & ~IRQ_VALID) == '0) && ((mask & ~IRQ_VALID) == '0));

endmodule

bind spi_irq_regs spi_irq_chk #(
    .FIFO_DEPTH (FIFO_DEPTH),
    .CNT_W      (CNT_W),
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_addr     (reg_addr),
    .reg_wr       (reg_wr),
    .reg_wdata    (reg_wdata),
    .tx_count     (tx_count),
    .rx_count     (rx_count),
    .rx_overflow  (rx_overflow),
    .tx_underflow (tx_underflow),
    .status       (status_q),
    .mask         (mask_q),
    .irq          (irq)
);

// File: tb/spi_irq_regs_tb.sv
module spi_irq_regs_tb;

    localparam int DEPTH  = 63;
    localparam int CNT_W  = 6;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic              reg_wr = 1'b0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic [CNT_W-1:0]  tx_count = '0;
    logic [CNT_W-1:0]  rx_count = '0;
    logic              rx_overflow = 1'b0;
    logic              tx_underflow = 1'b0;
    logic              irq;

    int    checks = 0;
    int    errors = 0;
    string req = "R10";
    bit    done = 1'b0;

    // reference model state
    int m_st, m_mk, m_twm, m_rwm;
    bit m_irq;

    always #10 clk = ~clk;

    spi_irq_regs #(
        .FIFO_DEPTH (DEPTH),
        .CNT_W      (CNT_W),
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_addr     (reg_addr),
        .reg_wr       (reg_wr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .tx_count     (tx_count),
        .rx_count     (rx_count),
        .rx_overflow  (rx_overflow),
        .tx_underflow (tx_underflow),
        .irq          (irq)
    );

    task automatic model_step();
        int ev;
        bit nirq;
        if (!rst_n) begin
            m_st = 0; m_mk = 0; m_twm = 1; m_rwm = 32; m_irq = 0;
            return;
        end
        nirq = ((m_st & m_mk) != 0);
        ev = 0;
        if (rx_overflow)                  ev = ev | 'h01;
        if (int'(tx_count) < m_twm)       ev = ev | 'h04;
        if (int'(tx_count) == DEPTH)      ev = ev | 'h08;
        if (int'(rx_count) >= m_rwm)      ev = ev | 'h10;
        if (int'(rx_count) == DEPTH)      ev = ev | 'h20;
        if (tx_underflow)                 ev = ev | 'h40;
        if (reg_wr) begin
            case (int'(reg_addr))
                'h04: m_st = m_st & ~int'(reg_wdata);
                'h08: m_mk = m_mk | int'(reg_wdata);
                'h0C: m_mk = m_mk & ~int'(reg_wdata);
                'h28: m_twm = int'(reg_wdata) & 'h3F;
                'h2C: m_rwm = int'(reg_wdata) & 'h3F;
                default: ;
            endcase
        end
        m_st  = (m_st | ev) & 'h7D;
        m_mk  = m_mk & 'h7D;
        m_irq = nirq;
    endtask

    function automatic int exp_rdata();
        case (int'(reg_addr))
            'h04: return m_st;
            'h10: return m_mk;
            'h28: return m_twm;
            'h2C: return m_rwm;
            default: return 0;
        endcase
    endfunction

    task automatic compare();
        checks++;
        if (irq !== m_irq) begin
            errors++;
            $display("FAIL %s irq: actual %0b expected %0b", req, irq, m_irq);
        end
        checks++;
        if (reg_rdata !== DATA_W'(exp_rdata())) begin
            errors++;
            $display("FAIL %s rdata @%02h: actual %08h expected %08h",
                     req, reg_addr, reg_rdata, exp_rdata());
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic wr(input int a, input int d);
        reg_addr  = ADDR_W'(a);
        reg_wdata = DATA_W'(d);
        reg_wr    = 1'b1;
        cyc();
        reg_wr    = 1'b0;
        reg_wdata = '0;
    endtask

    task automatic rd(input int a);
        reg_addr = ADDR_W'(a);
        cyc();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R10: reset state
        req = "R10";
        reg_addr = 8'h04;
        tx_count = 6'd0;
        rx_count = 6'd0;
        idle(3);
        rd('h10);
        rst_n = 1'b1;

        // R8: watermark reset values
        req = "R8";
        rd('h28);
        rd('h2C);

        // R2: tx_count 0 below watermark 1
        req = "R2";
        rd('h04);
        idle(2);

        // R6: set all mask bits, zeros elsewhere
        req = "R6";
        wr('h08, 'hFF);
        rd('h10);
        wr('h0C, 'h00);
        rd('h10);

        // R9: irq follows status & mask
        req = "R9";
        rd('h04);
        idle(2);

        // R5: clear with level still true, then clear when false
        req = "R5";
        wr('h04, 'h04);
        rd('h04);
        tx_count = 6'd5;
        wr('h04, 'h04);
        rd('h04);
        idle(2);

        // R3: rx watermark boundaries
        req = "R3";
        rx_count = 6'd31;
        rd('h04);
        rx_count = 6'd32;
        rd('h04);
        rx_count = 6'd31;
        wr('h04, 'h10);
        rd('h04);
        rx_count = 6'd33;
        rd('h04);
        rx_count = 6'd0;
        wr('h04, 'h10);

        // R1: full conditions
        req = "R1";
        tx_count = 6'd62;
        rd('h04);
        tx_count = 6'd63;
        rd('h04);
        rx_count = 6'd63;
        rd('h04);
        tx_count = 6'd5;
        rx_count = 6'd0;
        wr('h04, 'h38);
        rd('h04);

        // R4: sticky error bits
        req = "R4";
        rx_overflow = 1'b1;
        cyc();
        rx_overflow = 1'b0;
        idle(5);
        tx_underflow = 1'b1;
        cyc();
        tx_underflow = 1'b0;
        rd('h04);
        idle(4);
        wr('h04, 'h01);
        rd('h04);
        wr('h04, 'h40);
        rd('h04);

        // R7: mask offset ignores writes; set/clear offsets read 0
        req = "R7";
        wr('h10, 'h00);
        rd('h10);
        rd('h08);
        rd('h0C);
        wr('h0C, 'h7D);
        rd('h10);
        wr('h10, 'h7F);
        rd('h10);

        // R9: reserved bits never set; irq with partial mask
        req = "R9";
        wr('h08, 'hFFFF_FF82);
        rd('h10);
        rx_overflow = 1'b1;
        cyc();
        rx_overflow = 1'b0;
        rd('h04);
        wr('h0C, 'h01);
        idle(2);

        // R8 / R2: change watermarks
        req = "R8";
        wr('h28, 'h0A);
        rd('h28);
        wr('h2C, 'hC5);
        rd('h2C);
        req = "R2";
        wr('h08, 'h04);
        rd('h04);
        tx_count = 6'd10;
        wr('h04, 'h04);
        rd('h04);
        tx_count = 6'd9;
        idle(3);
        wr('h0C, 'h7F);
        idle(2);

        // R10: reset mid-run
        req = "R10";
        rst_n = 1'b0;
        rd('h04);
        rd('h10);
        rst_n = 1'b1;
        idle(2);

        finish_run();
    end

endmodule